// File: doc/BRIEF.md
# I2C Clock and Acknowledge Controller

This block is the clock side of a multi-master I2C port. When the shift logic asks for a byte transfer, the block toggles SCL through an open-drain pull-down. It produces eight clock pulses per byte, or nine when the acknowledge clock is on. On the ninth pulse it either drives the acknowledge onto SDA or releases SDA and samples the acknowledge sent by the far end. The choice depends on the transfer direction, on whether the byte is an address, and on an external address-match signal.

One 8-bit configuration register sets four things: the SCL divider code, standard or fast timing, the acknowledge level this block drives, and whether a ninth clock is generated at all. Byte shifting, START/STOP detection, arbitration and clock stretching are handled outside the block. A write to the register while a byte is in flight stops the clock generator at once and drops that byte.

Top module: `sclAckCtrl`

## Requirements
- R1: After reset, SCL and SDA are both released (`sclDriveLow`=0, `sdaDriveLow`=0), `busy`=0, `byteDone`=0 and `ackFlag`=1.
- R2: Every SCL low phase and every high phase lasts H system clocks. H = c*4 when register bit 5 is 0 and H = c*2 when bit 5 is 1, where c is register bits 4..0, with a code of 0 treated as 1.
- R3: After `xferStart` is accepted, SCL pulses 9 times when register bit 7 is 1 and 8 times when it is 0. A final low phase of H clocks follows, after which `busy` falls and SCL is released. The transfer occupies (2N+1)*H cycles.
- R4: When a data byte is received (`txDir`=0, `isAddrByte`=0) with bit 7 at 1, SDA is driven low for the whole ninth pulse (2H cycles) if register bit 6 is 0, and stays released if bit 6 is 1.
- R5: When an address byte is received with bit 7 at 1 and bit 6 at 0, SDA is driven low for the ninth pulse only if `addrMatch` is 1. With bit 6 at 1 it stays released whatever `addrMatch` is.
- R6: When transmitting (`txDir`=1), the block never drives SDA. With bit 7 at 1, `ackFlag` takes the `sdaIn` level present at the end of the ninth high phase.
- R7: `byteDone` is a one-cycle pulse that appears in the cycle SCL falls after the last pulse. `ackFlag` updates in that same cycle only when bit 7 is 1, and otherwise keeps its value.
- R8: A register write while `busy` is 1 returns the block to idle on the next cycle, with SCL and SDA released and no `byteDone`.
- R9: `xferStart` is ignored while `busy` is 1; the transfer length is unchanged.
- R10: SDA is never driven outside the ninth clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 8 | Register data: [4:0] divider code, [5] fast, [6] ack level high, [7] ack clock enable |
| xferStart | input | 1 | Request one byte transfer (accepted when idle) |
| txDir | input | 1 | 1 = this side sends the byte, 0 = it receives |
| isAddrByte | input | 1 | Byte being received is an address byte |
| addrMatch | input | 1 | Received address equals the own slave address |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDriveLow | output | 1 | Pull SCL low (open-drain) |
| sdaDriveLow | output | 1 | Pull SDA low (open-drain) |
| busy | output | 1 | Transfer in progress |
| byteDone | output | 1 | One-cycle pulse at the final SCL falling edge |
| ackFlag | output | 1 | Last sampled acknowledge level (0 = acknowledged) |

## Verification
The assertions assume several things about the inputs. `txDir` and `isAddrByte` are meaningful only when `xferStart` is accepted. `addrMatch` is stable throughout the ninth pulse. `sdaIn` is a synchronous level and needs no synchroniser. The stimulus sets these inputs before each start and holds them for the whole byte. It models the bus as a wired-AND of the block's SDA pull-down and a bench-side acknowledger. Register writes happen only while idle, except in the deliberate abort cases, which write partway through the second low phase.

// File: rtl/sclAckPkg.sv
package sclAckPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_TAIL = 2'd3
  } phaseE;

  typedef struct packed {
    logic loadCnt;    // reload the half-period counter
    logic clrPulse;   // restart pulse numbering
    logic incPulse;   // advance to next pulse
    logic latchXfer;  // capture direction and byte kind
    logic capAck;     // sample SDA as acknowledge
    logic inPulse;    // SCL is inside a numbered pulse
  } dpStrobeT;

endpackage

// File: rtl/sclAckPath.sv
module sclAckPath
  import sclAckPkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int STD_MUL   = 4,
  parameter int FAST_MUL  = 2,
  parameter int BYTE_BITS = 8,
  localparam int REG_W    = CODE_W + 3,
  localparam int MAX_MUL  = (STD_MUL > FAST_MUL) ? STD_MUL : FAST_MUL,
  localparam int HALF_W   = $clog2(((1 << CODE_W) - 1) * MAX_MUL + 1),
  localparam int PULSE_W  = $clog2(BYTE_BITS + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             txDir,
  input  logic             isAddrByte,
  input  logic             addrMatch,
  input  logic             sdaIn,
  input  dpStrobeT         strobe,
  output logic             cntZero,
  output logic             lastPulse,
  output logic             sdaDriveLow,
  output logic             ackFlag
);

  logic [REG_W-1:0]   cfgReg;
  logic [CODE_W-1:0]  cfgCode;
  logic               cfgFast;
  logic               cfgAckHigh;
  logic               cfgAckClk;
  logic [CODE_W-1:0]  effCode;
  logic [HALF_W-1:0]  halfLen;
  logic [HALF_W-1:0]  cnt;
  logic [PULSE_W-1:0] pulseIdx;
  logic               txLatched;
  logic               addrLatched;
  logic               ackPulse;
  logic               ackWanted;

  assign cfgCode    = cfgReg[CODE_W-1:0];
  assign cfgFast    = cfgReg[CODE_W];
  assign cfgAckHigh = cfgReg[CODE_W+1];
  assign cfgAckClk  = cfgReg[CODE_W+2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgReg <= '0;
    else if (regWrEn) cfgReg <= regWrData;
  end

  // Half-period length: code 0 clamps to 1, then scale by mode multiplier
  assign effCode = (cfgCode == '0) ? CODE_W'(1) : cfgCode;

  generate
    if (STD_MUL == FAST_MUL) begin : gOneMul
      assign halfLen = HALF_W'(effCode) * HALF_W'(STD_MUL);
    end else begin : gTwoMul
      assign halfLen = cfgFast ? HALF_W'(effCode) * HALF_W'(FAST_MUL)
                               : HALF_W'(effCode) * HALF_W'(STD_MUL);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.loadCnt) cnt <= halfLen - HALF_W'(1);
    else if (cnt != '0)      cnt <= cnt - HALF_W'(1);
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseIdx <= '0;
    else if (strobe.clrPulse) pulseIdx <= '0;
    else if (strobe.incPulse) pulseIdx <= pulseIdx + PULSE_W'(1);
  end

  assign lastPulse = cfgAckClk ? (pulseIdx == PULSE_W'(BYTE_BITS))
                               : (pulseIdx == PULSE_W'(BYTE_BITS - 1));
  assign ackPulse  = cfgAckClk && (pulseIdx == PULSE_W'(BYTE_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txLatched   <= 1'b1;
      addrLatched <= 1'b0;
    end else if (strobe.latchXfer) begin
      txLatched   <= txDir;
      addrLatched <= isAddrByte;
    end
  end

  // Receiver acknowledge: level bit low, and for addresses only on a match
  assign ackWanted   = !txLatched && !cfgAckHigh && (!addrLatched || addrMatch);
  assign sdaDriveLow = strobe.inPulse && ackPulse && ackWanted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ackFlag <= 1'b1;
    else if (strobe.capAck && cfgAckClk) ackFlag <= sdaIn;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inPulse |-> (cnt < halfLen)) else $error("cnt out of range"); // R2
  AST_SDA_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> (strobe.inPulse && !txLatched)) else $error("sda drive"); // R10
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capAck |=> $stable(ackFlag)) else $error("ackFlag moved"); // R7

endmodule

// File: rtl/sclAckSeq.sv
module sclAckSeq
  import sclAckPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWrEn,
  input  logic     xferStart,
  input  logic     cntZero,
  input  logic     lastPulse,
  output dpStrobeT strobe,
  output logic     sclDriveLow,
  output logic     busy,
  output logic     byteDone
);

  phaseE phase;
  phaseE phaseNext;
  logic  doneNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    doneNext  = 1'b0;
    strobe.inPulse = (phase == PH_LOW) || (phase == PH_HIGH);
    if (regWrEn) begin
      phaseNext = PH_IDLE;   // write resets the clock generator
    end else begin
      unique case (phase)
        PH_IDLE: if (xferStart) begin
          phaseNext        = PH_LOW;
          strobe.loadCnt   = 1'b1;
          strobe.clrPulse  = 1'b1;
          strobe.latchXfer = 1'b1;
        end
        PH_LOW: if (cntZero) begin
          phaseNext      = PH_HIGH;
          strobe.loadCnt = 1'b1;
        end
        PH_HIGH: if (cntZero) begin
          strobe.loadCnt = 1'b1;
          if (lastPulse) begin
            phaseNext     = PH_TAIL;
            strobe.capAck = 1'b1;
            doneNext      = 1'b1;
          end else begin
            phaseNext       = PH_LOW;
            strobe.incPulse = 1'b1;
          end
        end
        PH_TAIL: if (cntZero) phaseNext = PH_IDLE;
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      byteDone <= 1'b0;
    end else begin
      phase    <= phaseNext;
      byteDone <= doneNext;
    end
  end

  assign sclDriveLow = (phase == PH_LOW) || (phase == PH_TAIL);
  assign busy        = (phase != PH_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone) else $error("byteDone too long"); // R7
  AST_DONE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> sclDriveLow) else $error("byteDone with SCL high"); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> (!busy && !sclDriveLow)) else $error("no abort"); // R8
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclDriveLow) else $error("SCL held while idle"); // R1

endmodule

// File: rtl/sclAckCtrl.sv
module sclAckCtrl
  import sclAckPkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int STD_MUL   = 4,
  parameter int FAST_MUL  = 2,
  parameter int BYTE_BITS = 8,
  localparam int REG_W    = CODE_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             xferStart,
  input  logic             txDir,
  input  logic             isAddrByte,
  input  logic             addrMatch,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             byteDone,
  output logic             ackFlag
);

  dpStrobeT strobe;
  logic     cntZero;
  logic     lastPulse;

  sclAckSeq i_seq (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .xferStart   (xferStart),
    .cntZero     (cntZero),
    .lastPulse   (lastPulse),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow),
    .busy        (busy),
    .byteDone    (byteDone)
  );

  sclAckPath #(
    .CODE_W    (CODE_W),
    .STD_MUL   (STD_MUL),
    .FAST_MUL  (FAST_MUL),
    .BYTE_BITS (BYTE_BITS)
  ) i_path (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .txDir       (txDir),
    .isAddrByte  (isAddrByte),
    .addrMatch   (addrMatch),
    .sdaIn       (sdaIn),
    .strobe      (strobe),
    .cntZero     (cntZero),
    .lastPulse   (lastPulse),
    .sdaDriveLow (sdaDriveLow),
    .ackFlag     (ackFlag)
  );

endmodule

// File: tb/test_sclAckCtrl.sv
module test_sclAckCtrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       xferStart = 1'b0;
  logic       txDir = 1'b0;
  logic       isAddrByte = 1'b0;
  logic       addrMatch = 1'b0;
  logic       slaveAckLow = 1'b0;
  logic       sdaIn;
  logic       sclDriveLow, sdaDriveLow, busy, byteDone, ackFlag;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign sdaIn = !(sdaDriveLow || slaveAckLow);

  sclAckCtrl i_sclAckCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .xferStart(xferStart), .txDir(txDir), .isAddrByte(isAddrByte),
    .addrMatch(addrMatch), .sdaIn(sdaIn), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .busy(busy), .byteDone(byteDone),
    .ackFlag(ackFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWrData = v;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, lowLen, highLen, pulses, sdaCyc, doneCnt, busyLen, idx;
    int nPulse, expSda, expAck, prevAck;
    logic prevScl, drive;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl", sclDriveLow, 0);
    chk("R1 sda", sdaDriveLow, 0);
    chk("R1 busy", busy, 0);
    chk("R1 byteDone", byteDone, 0);
    chk("R1 ackFlag", ackFlag, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R8 sweep over every code and both modes
    for (int fast = 0; fast < 2; fast++) begin
      for (int code = 0; code < 32; code++) begin
        h = ((code == 0) ? 1 : code) * ((fast != 0) ? 2 : 4);
        writeReg({1'b1, 1'b0, fast[0], code[4:0]});
        xferStart = 1'b1;
        @(negedge clk);
        xferStart = 1'b0;
        lowLen = 0;
        highLen = 0;
        while (sclDriveLow) begin lowLen++; @(negedge clk); end
        while (!sclDriveLow && busy) begin highLen++; @(negedge clk); end
        chk("R2 low phase", lowLen, h);
        chk("R2 high phase", highLen, h);
        writeReg(8'h81);   // abort inside second low phase
        chk("R8 busy after write", busy, 0);
        chk("R8 scl released", sclDriveLow, 0);
        chk("R8 no byteDone", byteDone, 0);
      end
    end

    // R3..R7, R9, R10 over acknowledge configurations, H = 4
    prevAck = ackFlag;
    for (int ac = 0; ac < 2; ac++)
      for (int ah = 0; ah < 2; ah++)
        for (int tx = 0; tx < 2; tx++)
          for (int ad = 0; ad < 2; ad++)
            for (int m = 0; m < 2; m++) begin
              h = 4;
              writeReg({ac[0], ah[0], 1'b0, 5'd1});
              txDir = tx[0];
              isAddrByte = ad[0];
              addrMatch = m[0];
              slaveAckLow = (tx != 0) ? m[0] : 1'b0;
              nPulse = (ac != 0) ? 9 : 8;
              drive = (ac != 0) && (tx == 0) && (ah == 0) && ((ad == 0) || (m != 0));
              expSda = drive ? 2 * h : 0;
              if (ac == 0)      expAck = prevAck;
              else if (tx != 0) expAck = (m != 0) ? 0 : 1;
              else              expAck = drive ? 0 : 1;
              xferStart = 1'b1;
              @(negedge clk);
              xferStart = 1'b0;
              pulses = 0; sdaCyc = 0; doneCnt = 0; busyLen = 0; idx = 0;
              prevScl = 1'b1;
              while (busy) begin
                busyLen++;
                if (prevScl && !sclDriveLow) pulses++;
                if (sdaDriveLow) sdaCyc++;
                if (byteDone && sclDriveLow && !prevScl) doneCnt++;
                prevScl = sclDriveLow;
                xferStart = (idx == 10);   // R9 start while busy
                idx++;
                @(negedge clk);
              end
              xferStart = 1'b0;
              chk("R3 pulses", pulses, nPulse);
              chk("R3 R9 busy length", busyLen, (2 * nPulse + 1) * h);
              chk("R4 R5 R6 R10 sda low cycles", sdaCyc, expSda);
              chk("R7 byteDone pulses", doneCnt, 1);
              chk("R6 R7 ackFlag", ackFlag, expAck);
              prevAck = ackFlag;
              slaveAckLow = 1'b0;
              @(negedge clk);
            end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule